// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Scanner

This block drives a multiplexed liquid-crystal panel of up to four commons and thirty-two segments. It does not make voltages. Each pin gets a 2-bit drive-level code, and an analog stage outside the block turns that code into the actual voltage. A scan tick comes from outside, divided down from the 32768 Hz low-speed clock. Each tick moves the scan to the next active common. After the last active common, the drive polarity reverses, so that over two frames every pixel sees no net DC.

Software configures the block through a small write-only register bus. Addresses 0 to 3 hold one pattern word for each common. Address 4 is the option word, which selects the duty (the number of active commons), the bias (three or four levels) and the share mode. Writing the option word starts the scan. The index of the common being served is always visible on an output.

In share mode the scanner reads every common's segments from pattern word 0. It raises a one-cycle service pulse on each step, so that software can reload word 0 with the next common's pattern.

Top module: `lcd_mux_scanner`

## Requirements
- R1: After reset the display is off: every common and segment code is 00 (VSS), `cur_com` is 0 and `svc_tick` is 0.
- R2: A write to address 4 loads the option word. Bits [1:0] are the duty (0 = blank, 1 = two commons, 2 = three, 3 = four), bit 2 is the bias (1 = third bias, 0 = half bias) and bit 3 is share mode. A nonzero duty turns the display on. Duty 0 turns it off, with all outputs at 00. Every option write restarts the scan at common 0 with positive polarity.
- R3: While the display is on, each cycle with `scan_tick` high advances `cur_com` from 0 up to duty, then wraps to 0. The update is visible one clock after the tick.
- R4: Level codes are 00 = VSS, 01 = lower inner level, 10 = upper inner level (the middle level at half bias), 11 = VDD. The served common is 11 at positive polarity and 00 at negative polarity. Every other common, including commons beyond the duty, takes the non-select level: 10 at half bias, and at third bias 01 for positive polarity and 10 for negative polarity.
- R5: A segment whose pattern bit is 1 takes the extreme opposite the served common (00 at positive polarity, 11 at negative). A segment whose bit is 0 takes 10 (positive) or 01 (negative) at third bias, and at half bias takes the same extreme as the served common.
- R6: The polarity reverses on the tick that wraps the scan from the last active common back to common 0, and only on that tick.
- R7: Writes to addresses 0 to 3 store the pattern word of common 0 to 3, and segment bit j comes from bit j of the served common's word. Writes to addresses 5 to 7 have no effect.
- R8: In share mode every common's segments come from pattern word 0. Each scan step raises `svc_tick` for exactly one cycle, in the same cycle in which `cur_com` shows the new common. Outside share mode `svc_tick` stays 0.
- R9: While the display is off, `scan_tick` has no effect: the outputs stay at 00 and `cur_com` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle pulse per common slot, from the low-speed divider |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0-3 patterns, 4 option) |
| reg_wdata | input | 32 | Register write data |
| com_lvl | output | 8 | Drive code per common, common k at bits [2k+1:2k] |
| seg_lvl | output | 64 | Drive code per segment, segment j at bits [2j+1:2j] |
| cur_com | output | 2 | Index of the common being served |
| svc_tick | output | 1 | Share-mode service pulse |

## Verification
The bench walks every duty through more than one frame, so the polarity flip at the wrap point is checked at each frame length. A scanner that wrapped one common late, or flipped polarity on every step, would put the select pulse on the wrong common or leave a DC term on the panel. Half bias is checked for the rule that an off segment follows the served common, and the check would catch a design that used an inner level there. The bench also checks that at a duty of three the unused fourth common is held at the non-select level rather than being scanned. The share-mode checks reload word 0 between ticks, so they catch a design that indexes the per-common words or drops the service pulse. Writes to unused addresses and ticks while the display is blank must leave the outputs untouched.

// File: rtl/lcd_mux_scanner.sv
module lcd_mux_scanner #(
  parameter int NSEG = 32,
  parameter int NCOM = 4,
  localparam int CW  = $clog2(NCOM),
  localparam int AW  = $clog2(NCOM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_tick,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [NSEG-1:0]     reg_wdata,
  output logic [2*NCOM-1:0]   com_lvl,
  output logic [2*NSEG-1:0]   seg_lvl,
  output logic [CW-1:0]       cur_com,
  output logic                svc_tick
);
  localparam logic [1:0]    L_VSS = 2'b00;
  localparam logic [1:0]    L_LO  = 2'b01;
  localparam logic [1:0]    L_HI  = 2'b10;
  localparam logic [1:0]    L_VDD = 2'b11;
  localparam logic [AW-1:0] A_OPT = AW'(NCOM);

  logic [NSEG-1:0] pat [NCOM];
  logic            on_q, bias3_q, share_q, pol_q, svc_q;
  logic [1:0]      duty_q;
  logic [CW-1:0]   idx_q;

  wire opt_wr  = reg_we && (reg_addr == A_OPT);
  wire at_last = (idx_q == CW'(duty_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      duty_q  <= 2'd0;
      bias3_q <= 1'b0;
      share_q <= 1'b0;
      pol_q   <= 1'b0;
      idx_q   <= '0;
      svc_q   <= 1'b0;
    end else if (opt_wr) begin
      duty_q  <= reg_wdata[1:0];
      bias3_q <= reg_wdata[2];
      share_q <= reg_wdata[3];
      on_q    <= (reg_wdata[1:0] != 2'd0);
      pol_q   <= 1'b0;
      idx_q   <= '0;
      svc_q   <= 1'b0;
    end else if (scan_tick && on_q) begin
      idx_q   <= at_last ? '0 : idx_q + 1'b1;
      pol_q   <= at_last ? ~pol_q : pol_q;
      svc_q   <= share_q;
    end else begin
      svc_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCOM; k++) pat[k] <= '0;
    end else if (reg_we && (reg_addr < A_OPT)) begin
      pat[reg_addr[CW-1:0]] <= reg_wdata;
    end
  end

  wire [1:0] sel_lvl = pol_q ? L_VSS : L_VDD;
  wire [1:0] uns_lvl = (bias3_q && !pol_q) ? L_LO : L_HI;
  wire [1:0] on_lvl  = pol_q ? L_VDD : L_VSS;
  wire [1:0] off_lvl = bias3_q ? (pol_q ? L_LO : L_HI) : sel_lvl;
  wire [NSEG-1:0] row = share_q ? pat[0] : pat[idx_q];

  for (genvar k = 0; k < NCOM; k++) begin : g_com
    assign com_lvl[2*k +: 2] = !on_q ? L_VSS :
                               (idx_q == CW'(k)) ? sel_lvl : uns_lvl;
  end

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    assign seg_lvl[2*j +: 2] = !on_q ? L_VSS : (row[j] ? on_lvl : off_lvl);
  end

  assign cur_com  = idx_q;
  assign svc_tick = svc_q;
endmodule

// File: rtl/lcd_mux_scanner_chk.sv
module lcd_mux_scanner_chk #(
  parameter int NSEG = 32,
  parameter int NCOM = 4,
  localparam int CW  = $clog2(NCOM)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_tick,
  input logic              reg_we,
  input logic [2*NCOM-1:0] com_lvl,
  input logic [2*NSEG-1:0] seg_lvl,
  input logic [CW-1:0]     cur_com,
  input logic              svc_tick,
  input logic              on_q,
  input logic              bias3_q,
  input logic              share_q,
  input logic              pol_q,
  input logic [1:0]        duty_q
);
  int   n_ext;
  logic has_lo;

  always_comb begin
    n_ext  = 0;
    has_lo = 1'b0;
    for (int k = 0; k < NCOM; k++) begin
      if (com_lvl[2*k +: 2] == 2'b00 || com_lvl[2*k +: 2] == 2'b11) n_ext++;
      if (com_lvl[2*k +: 2] == 2'b01) has_lo = 1'b1;
    end
    for (int j = 0; j < NSEG; j++)
      if (seg_lvl[2*j +: 2] == 2'b01) has_lo = 1'b1;
  end

  a_r1_blank_vss: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |-> (com_lvl == '0 && seg_lvl == '0));

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> (cur_com <= CW'(duty_q)));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && scan_tick && !reg_we) |=>
      cur_com == (($past(cur_com) == CW'($past(duty_q))) ? CW'(0) : CW'($past(cur_com) + 1'b1)));

  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> (n_ext == 1));

  a_r5_half_no_low: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && !bias3_q) |-> !has_lo);

  a_r6_pol_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && scan_tick && !reg_we && cur_com == CW'(duty_q)) |=> (pol_q != $past(pol_q)));

  a_r8_svc_share: assert property (@(posedge clk) disable iff (!rst_n)
    svc_tick |-> share_q);

  a_r8_svc_single: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_tick && !scan_tick) |=> !svc_tick);
endmodule

bind lcd_mux_scanner lcd_mux_scanner_chk #(.NSEG(NSEG), .NCOM(NCOM)) u_chk (.*);

// File: tb/lcd_mux_scanner_test.sv
module lcd_mux_scanner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  com_lvl;
  logic [63:0] seg_lvl;
  logic [1:0]  cur_com;
  logic        svc_tick;

  lcd_mux_scanner uut (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  logic        e_on = 0, e_b3 = 0, e_sh = 0, e_pol = 0, e_svc = 0;
  int          e_duty = 0, e_idx = 0;
  logic [31:0] e_pat [4] = '{default: '0};

  function automatic logic [1:0] exp_com(int k);
    if (!e_on) return 2'b00;
    if (k == e_idx) return e_pol ? 2'b00 : 2'b11;
    return (e_b3 && !e_pol) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] exp_seg(int j);
    logic [31:0] w;
    if (!e_on) return 2'b00;
    w = e_sh ? e_pat[0] : e_pat[e_idx];
    if (w[j]) return e_pol ? 2'b11 : 2'b00;
    if (e_b3) return e_pol ? 2'b01 : 2'b10;
    return e_pol ? 2'b00 : 2'b11;
  endfunction

  task automatic check_all(input string tag);
    logic [7:0]  ec;
    logic [63:0] es;
    for (int k = 0; k < 4; k++) ec[2*k +: 2] = exp_com(k);
    for (int j = 0; j < 32; j++) es[2*j +: 2] = exp_seg(j);
    checks++;
    if (com_lvl !== ec) begin
      errors++;
      $display("FAIL %s com_lvl: got %h expected %h", tag, com_lvl, ec);
    end
    checks++;
    if (seg_lvl !== es) begin
      errors++;
      $display("FAIL %s seg_lvl: got %h expected %h", tag, seg_lvl, es);
    end
    checks++;
    if (cur_com !== 2'(e_idx) || svc_tick !== e_svc) begin
      errors++;
      $display("FAIL %s cur_com/svc: got %0d/%b expected %0d/%b", tag, cur_com, svc_tick, e_idx, e_svc);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    e_svc = 0;
    if (a < 4) e_pat[a] = d;
    else if (a == 4) begin
      e_duty = int'(d[1:0]); e_b3 = d[2]; e_sh = d[3];
      e_on = (d[1:0] != 0); e_idx = 0; e_pol = 0;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    scan_tick = 1'b1;
    @(negedge clk);
    scan_tick = 1'b0;
    e_svc = 0;
    if (e_on) begin
      if (e_idx == e_duty) begin e_idx = 0; e_pol = ~e_pol; end
      else e_idx++;
      e_svc = e_sh;
    end
  endtask

  task automatic t_reset();
    check_all("R1 reset state");
  endtask

  task automatic t_off_ticks();
    for (int i = 0; i < 3; i++) tick();
    check_all("R9 tick while off");
  endtask

  task automatic t_third_bias_full_duty();
    wr(0, 32'hA5A5_0F0F); wr(1, 32'hFFFF_0000);
    wr(2, 32'h0000_FFFF); wr(3, 32'h1234_5678);
    check_all("R7 patterns while off");
    wr(4, 32'h7);
    check_all("R2 enable third bias four commons");
    for (int i = 0; i < 9; i++) begin
      tick();
      check_all("R3 R4 R5 R6 third bias scan");
    end
  endtask

  task automatic t_bad_addr();
    wr(5, 32'hFFFF_FFFF);
    wr(7, 32'h0);
    check_all("R7 addresses 5 and 7 ignored");
    wr(6, 32'h0000_0003);
    check_all("R7 address 6 ignored");
  endtask

  task automatic t_half_bias_three();
    tick();
    wr(4, 32'h2);
    check_all("R2 restart at common 0");
    for (int i = 0; i < 7; i++) begin
      tick();
      check_all("R4 R5 R6 half bias three commons");
    end
  endtask

  task automatic t_two_commons();
    wr(4, 32'h5);
    for (int i = 0; i < 5; i++) begin
      tick();
      check_all("R3 R6 two commons");
    end
  endtask

  task automatic t_share();
    wr(4, 32'hF);
    check_all("R8 share enable");
    for (int i = 0; i < 6; i++) begin
      wr(0, 32'h0101_0101 << i);
      check_all("R8 share no pulse between steps");
      tick();
      check_all("R8 share step");
    end
  endtask

  task automatic t_blank();
    wr(4, 32'h4);
    check_all("R2 blank option");
    tick(); tick();
    check_all("R9 ticks ignored when blanked");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off_ticks();
    t_third_bias_full_duty();
    t_bad_addr();
    t_half_bias_three();
    t_two_commons();
    t_share();
    t_blank();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule